// File: doc/BRIEF.md
# One-Wire Bus Timing Master

This block produces every waveform a one-wire bus master needs: a reset pulse with presence detection, single bit slots (write 0, write 1, read), and whole bytes sent or received least significant bit first. All delays are counted in enables of a one-microsecond tick, so the block runs from any system clock. A speed input chooses standard or overdrive slot timing. The choice is latched when a command is accepted.

A command is accepted only while the block is idle. `busy` stays high until the operation finishes. `done` then pulses for one cycle, and the presence result, read bit or read byte is valid. Presence is judged from a burst of thirty samples on successive clock cycles, and any low sample counts as a device answering. A reset that sees no device is repeated, up to three attempts in total. A byte write can optionally drive the line actively high for a short strong pull-up phase before the first bit, before the last bit, and after the last bit.

The line is driven in one of two ways. In open-drain mode the output enable is always on and the pin value carries the level. In the other mode a low is driven with the enable on and the value at 0, and a high is produced by switching the enable off.

The state machine has these states: IDLE, RST_LOW, RST_WAIT, RST_SAMPLE, RST_RECOV, PULLUP, SLOT_LOW, SLOT_HOLD, SLOT_SAMPLE and SLOT_TAIL. Its transitions are:

- IDLE to RST_LOW on a reset command.
- IDLE to PULLUP on a byte write with pull-up requested.
- IDLE to SLOT_HOLD for a write of 0.
- IDLE to SLOT_LOW otherwise.
- RST_LOW to RST_WAIT, RST_WAIT to RST_SAMPLE, and RST_SAMPLE to RST_RECOV, each when its time is up.
- RST_RECOV to RST_LOW for a retry, or to IDLE.
- SLOT_LOW to SLOT_SAMPLE for reads, or to SLOT_TAIL for a write of 1.
- SLOT_HOLD to SLOT_TAIL, and SLOT_SAMPLE to SLOT_TAIL.
- SLOT_TAIL to the next slot, to PULLUP, or to IDLE.
- PULLUP to the next slot, or to IDLE after the final phase.

Top module: `ow_master`

## Requirements
- R1: After reset `busy`, `done`, `presence`, `rd_bit` and `rd_byte` are 0. In the non-open-drain mode `line_oe` is 0.
- R2: A write-1 slot (command code 1 with `cmd_byte[0]`=1) drives the line low for exactly one clock cycle and then releases it for 64 ticks (standard) or 10 ticks (overdrive).
- R3: A write-0 slot (command code 1 with `cmd_byte[0]`=0) holds the line low for 60 ticks (standard) or 8 ticks (overdrive) and then releases it for 10 or 5 ticks.
- R4: A read slot (command code 2) drives the line low for one cycle and releases it. The line is sampled in the next cycle as `rd_bit`, and the slot then waits 55 ticks (standard) or 8 ticks (overdrive).
- R5: A reset attempt (command code 0) holds the line low for 500 or 50 ticks. It then waits 60 or 1 ticks, takes 30 samples, and waits 1000 or 40 ticks.
- R6: The 30 presence samples fall on consecutive clock cycles. A single low in any of them sets `presence`=1. Lows just before or just after the window are not counted.
- R7: An attempt that sees no presence is repeated, up to 3 attempts in total. The sequence stops after the first attempt that sees presence.
- R8: A byte write (code 3) sends `cmd_byte` bit 0 first, and a byte read (code 4) places the first received bit in `rd_byte[0]`. Each bit takes one slot with the timing of R2 to R4.
- R9: With `od_mode`=1, `line_oe` stays 1 and `line_out` carries the line level. With `od_mode`=0, a low is `line_oe`=1 with `line_out`=0, and a release is `line_oe`=0.
- R10: With `spu_en`=1 on a byte write, the line is actively driven high (`line_oe`=1, `line_out`=1) for PU_TICKS ticks at three points: before bit 0, before bit 7, and after bit 7. Without the request it is never driven high.
- R11: A command is taken only in IDLE with `cmd_valid`=1 and a code from 0 to 4. Codes 5 to 7, and any command while `busy`=1, are ignored. `done` pulses for one cycle as `busy` falls.
- R12: Every timed phase counts `tick_us` enables, not clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-microsecond tick enable |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 reset, 1 write bit, 2 read bit, 3 write byte, 4 read byte |
| cmd_byte | input | 8 | Byte to send; bit 0 is the value for a bit write |
| speed_od | input | 1 | 1 selects overdrive timing |
| od_mode | input | 1 | 1 selects open-drain pin-value drive |
| spu_en | input | 1 | Strong pull-up request for byte writes |
| line_in | input | 1 | Sampled bus level |
| line_oe | output | 1 | Pin output enable |
| line_out | output | 1 | Pin output value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| presence | output | 1 | A device answered the last reset |
| rd_bit | output | 1 | Last sampled read bit |
| rd_byte | output | 8 | Last received byte |

## Verification
Byte writes are swept over all 256 values at overdrive speed. Each transmitted bit is recovered from the length of its low pulse, which separates a bit-order fault from a slot-length fault. Byte reads are swept over all 256 patterns supplied by a bench responder. Reset is run with a responder that answers on the first attempt, on the second attempt, or never, which shows whether the retry count and the early stop work. Single-cycle presence lows are placed on the first and last sample of the window and one cycle outside it on each side. Further runs cover slot lengths at both speeds, open-drain drive, the strong pull-up, a command issued mid-operation, an illegal code and a slowed tick.

// File: rtl/ow_pkg.sv
package ow_pkg;
    typedef enum logic [2:0] {
        OP_RESET = 3'd0,
        OP_WBIT  = 3'd1,
        OP_RBIT  = 3'd2,
        OP_WBYTE = 3'd3,
        OP_RBYTE = 3'd4
    } ow_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RST_LOW, ST_RST_WAIT, ST_RST_SAMPLE, ST_RST_RECOV,
        ST_PULLUP, ST_SLOT_LOW, ST_SLOT_HOLD, ST_SLOT_SAMPLE, ST_SLOT_TAIL
    } ow_state_e;

    typedef enum logic [1:0] {
        PU_PRE, PU_MID, PU_POST
    } ow_pu_e;
endpackage

// File: rtl/ow_tick_timer.sv
module ow_tick_timer #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = tick && (cnt == CNT_W'(1));

    // R12: the count only moves on a tick or a reload
    p_count_on_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
endmodule

// File: rtl/ow_presence.sv
module ow_presence #(
    parameter int N_SAMPLES = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic line_in,
    output logic fin,
    output logic found
);
    localparam int SW = $clog2(N_SAMPLES + 1);
    logic [SW-1:0] cnt;
    logic          low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            low_q <= 1'b0;
        end else if (!en) begin
            cnt   <= '0;
            low_q <= 1'b0;
        end else begin
            cnt   <= cnt + 1'b1;
            low_q <= low_q | ~line_in;
        end
    end

    assign fin   = en && (cnt == SW'(N_SAMPLES - 1));
    assign found = low_q | ~line_in;

    // R6: the burst never runs past its sample count
    p_window_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (cnt < SW'(N_SAMPLES)));
endmodule

// File: rtl/ow_master.sv
module ow_master
    import ow_pkg::*;
#(
    parameter int N_SAMPLES   = 30,
    parameter int MAX_TRIES   = 3,
    parameter int PU_TICKS    = 4,
    parameter int T_W1_STD    = 64,
    parameter int T_W1_OD     = 10,
    parameter int T_W0LO_STD  = 60,
    parameter int T_W0LO_OD   = 8,
    parameter int T_W0REC_STD = 10,
    parameter int T_W0REC_OD  = 5,
    parameter int T_RD_STD    = 55,
    parameter int T_RD_OD     = 8,
    parameter int T_RLO_STD   = 500,
    parameter int T_RLO_OD    = 50,
    parameter int T_RWT_STD   = 60,
    parameter int T_RWT_OD    = 1,
    parameter int T_RREC_STD  = 1000,
    parameter int T_RREC_OD   = 40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_us,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    input  logic [7:0] cmd_byte,
    input  logic       speed_od,
    input  logic       od_mode,
    input  logic       spu_en,
    input  logic       line_in,
    output logic       line_oe,
    output logic       line_out,
    output logic       busy,
    output logic       done,
    output logic       presence,
    output logic       rd_bit,
    output logic [7:0] rd_byte
);
    localparam int T_SUM = T_W1_STD + T_W0LO_STD + T_W0REC_STD + T_RD_STD + T_RLO_STD
                         + T_RWT_STD + T_RREC_STD + PU_TICKS + T_RREC_OD + T_RLO_OD;
    localparam int CNT_W = $clog2(T_SUM + 1);
    localparam int ATT_W = $clog2(MAX_TRIES + 1);

    ow_state_e        state, state_n;
    ow_op_e           op_q;
    ow_pu_e           pu_ph;
    logic             spu_q, od_q, pres_q;
    logic [2:0]       idx;
    logic [7:0]       sh;
    logic [ATT_W-1:0] att;
    logic             tmr_exp, pres_fin, pres_found;
    logic [CNT_W-1:0] dur_n;
    logic             accept, spd, is_wr, is_rd, last_bit, mid_pu, wr_in;

    assign accept = (state == ST_IDLE) && cmd_valid && (cmd_op <= 3'd4);
    assign spd    = (state == ST_IDLE) ? speed_od : od_q;
    assign is_wr  = (op_q == OP_WBIT) || (op_q == OP_WBYTE);
    assign is_rd  = (op_q == OP_RBIT) || (op_q == OP_RBYTE);
    assign wr_in  = (cmd_op == 3'(OP_WBIT)) || (cmd_op == 3'(OP_WBYTE));
    assign last_bit = ((op_q != OP_WBYTE) && (op_q != OP_RBYTE)) || (idx == 3'd7);
    assign mid_pu   = (op_q == OP_WBYTE) && spu_q && (idx == 3'd6);

    function automatic ow_state_e slot_start(input logic wr, input logic b);
        return (wr && !b) ? ST_SLOT_HOLD : ST_SLOT_LOW;
    endfunction

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) begin
                if (cmd_op == 3'(OP_RESET))
                    state_n = ST_RST_LOW;
                else if (cmd_op == 3'(OP_WBYTE) && spu_en)
                    state_n = ST_PULLUP;
                else
                    state_n = slot_start(wr_in, cmd_byte[0]);
            end
            ST_RST_LOW:    if (tmr_exp) state_n = ST_RST_WAIT;
            ST_RST_WAIT:   if (tmr_exp) state_n = ST_RST_SAMPLE;
            ST_RST_SAMPLE: if (pres_fin) state_n = ST_RST_RECOV;
            ST_RST_RECOV:  if (tmr_exp)
                state_n = (pres_q || att == ATT_W'(MAX_TRIES - 1)) ? ST_IDLE : ST_RST_LOW;
            ST_PULLUP:     if (tmr_exp)
                state_n = (pu_ph == PU_POST) ? ST_IDLE : slot_start(is_wr, sh[0]);
            ST_SLOT_LOW:    state_n = is_rd ? ST_SLOT_SAMPLE : ST_SLOT_TAIL;
            ST_SLOT_HOLD:   if (tmr_exp) state_n = ST_SLOT_TAIL;
            ST_SLOT_SAMPLE: state_n = ST_SLOT_TAIL;
            ST_SLOT_TAIL:   if (tmr_exp) begin
                if (last_bit)
                    state_n = (op_q == OP_WBYTE && spu_q) ? ST_PULLUP : ST_IDLE;
                else if (mid_pu)
                    state_n = ST_PULLUP;
                else
                    state_n = slot_start(is_wr, sh[1]);
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // phase length loaded on entry to each timed state
    always_comb begin
        unique case (state_n)
            ST_RST_LOW:   dur_n = CNT_W'(spd ? T_RLO_OD  : T_RLO_STD);
            ST_RST_WAIT:  dur_n = CNT_W'(spd ? T_RWT_OD  : T_RWT_STD);
            ST_RST_RECOV: dur_n = CNT_W'(spd ? T_RREC_OD : T_RREC_STD);
            ST_PULLUP:    dur_n = CNT_W'(PU_TICKS);
            ST_SLOT_HOLD: dur_n = CNT_W'(spd ? T_W0LO_OD : T_W0LO_STD);
            ST_SLOT_TAIL:
                if (is_rd)       dur_n = CNT_W'(spd ? T_RD_OD    : T_RD_STD);
                else if (sh[0])  dur_n = CNT_W'(spd ? T_W1_OD    : T_W1_STD);
                else             dur_n = CNT_W'(spd ? T_W0REC_OD : T_W0REC_STD);
            default:      dur_n = '0;
        endcase
    end

    ow_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(state_n != state), .load_val(dur_n),
        .tick(tick_us), .expire(tmr_exp)
    );

    ow_presence #(.N_SAMPLES(N_SAMPLES)) u_pres (
        .clk(clk), .rst_n(rst_n), .en(state == ST_RST_SAMPLE), .line_in(line_in),
        .fin(pres_fin), .found(pres_found)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // command, shift and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_RESET; spu_q <= 1'b0; od_q <= 1'b0; sh <= '0; idx <= '0;
            att <= '0; pu_ph <= PU_PRE; pres_q <= 1'b0; presence <= 1'b0;
            rd_bit <= 1'b0; rd_byte <= '0; done <= 1'b0;
        end else begin
            done <= (state != ST_IDLE) && (state_n == ST_IDLE);
            if (accept) begin
                op_q <= ow_op_e'(cmd_op); spu_q <= spu_en; od_q <= speed_od;
                sh <= cmd_byte; idx <= '0; att <= '0;
            end
            if (state_n == ST_PULLUP && state != ST_PULLUP)
                pu_ph <= (state == ST_IDLE) ? PU_PRE : (last_bit ? PU_POST : PU_MID);
            if (pres_fin)
                pres_q <= pres_found;
            if (state == ST_RST_RECOV && tmr_exp) begin
                if (state_n == ST_RST_LOW) att <= att + 1'b1;
                else                       presence <= pres_q;
            end
            if (state == ST_SLOT_SAMPLE) begin
                sh     <= {line_in, sh[7:1]};
                rd_bit <= line_in;
                if (op_q == OP_RBYTE && idx == 3'd7)
                    rd_byte <= {line_in, sh[7:1]};
            end
            if (state == ST_SLOT_TAIL && tmr_exp && !last_bit) begin
                idx <= idx + 1'b1;
                if (is_wr) sh <= {1'b0, sh[7:1]};
            end
        end
    end

    // outputs
    always_comb begin
        logic drv_low, drv_high;
        drv_low  = (state == ST_RST_LOW) || (state == ST_SLOT_LOW) || (state == ST_SLOT_HOLD);
        drv_high = (state == ST_PULLUP);
        busy     = (state != ST_IDLE);
        if (od_mode) begin
            line_oe  = 1'b1;
            line_out = ~drv_low;
        end else begin
            line_oe  = drv_low | drv_high;
            line_out = drv_high;
        end
    end

    p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_start_needs_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));
    p_release_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !od_mode) |-> !line_oe);
    p_pullup_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PULLUP) |-> (op_q == OP_WBYTE && spu_q));
    p_tries_r7: assert property (@(posedge clk) disable iff (!rst_n)
        att < ATT_W'(MAX_TRIES));
endmodule

// File: tb/ow_master_test.sv
module ow_master_test;
    logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1, sparse = 1'b0;
    logic cmd_valid = 1'b0, speed_od = 1'b0, od_mode = 1'b0, spu_en = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_byte = 8'd0;
    logic line_in, line_oe, line_out, busy, done, presence, rd_bit;
    logic [7:0] rd_byte;

    int checks = 0, errors = 0;
    bit timeout = 1'b0, reported = 1'b0;
    int cycles = 0;

    // responder configuration
    int s_answer_at = 0, s_lo = 0, s_hi = 0;
    logic s_rd_mode = 1'b0;
    logic [7:0] s_rd_pat = 8'hFF;
    int rel_cnt = 100000, low_len = 0, rst_seen = 0, ridx = 0;

    // monitor results
    int run = 0, last_run = 0, falls = 0, hi_cnt = 0, oe_gap = 0, busy_cyc = 0;
    int min_run = 0, max_run = 0;
    logic [7:0] wr_cap = 8'd0;

    logic m_low, s_low;
    assign m_low = line_oe & ~line_out;
    assign s_low = (s_answer_at != 0 && rst_seen >= s_answer_at && rel_cnt >= s_lo && rel_cnt <= s_hi)
                 || (s_rd_mode && busy && !s_rd_pat[ridx[2:0]] && rel_cnt < 3);
    assign line_in = ~(m_low | s_low);

    ow_master uut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_byte(cmd_byte), .speed_od(speed_od), .od_mode(od_mode), .spu_en(spu_en),
        .line_in(line_in), .line_oe(line_oe), .line_out(line_out), .busy(busy), .done(done),
        .presence(presence), .rd_bit(rd_bit), .rd_byte(rd_byte)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) tick <= sparse ? ~tick : 1'b1;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) timeout <= 1'b1;
        if (m_low) begin
            rel_cnt <= 0;
            low_len <= low_len + 1;
        end else begin
            if (rel_cnt < 100000) rel_cnt <= rel_cnt + 1;
            low_len <= 0;
            if (low_len >= 40) rst_seen <= rst_seen + 1;
        end
        if (!busy) begin
            rst_seen <= 0;
            ridx <= 0;
        end else if (s_rd_mode && !m_low && rel_cnt == 5)
            ridx <= ridx + 1;
    end

    always @(negedge clk) begin
        if (m_low) run = run + 1;
        else if (run > 0) begin
            last_run = run;
            if (min_run == 0 || run < min_run) min_run = run;
            if (run > max_run) max_run = run;
            falls = falls + 1;
            wr_cap = {(run == 1), wr_cap[7:1]};
            run = 0;
        end
        if (line_oe && line_out && !od_mode) hi_cnt = hi_cnt + 1;
        if (od_mode && !line_oe) oe_gap = oe_gap + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input logic [7:0] b, input logic od,
                           input logic spu, input int inj_at);
        int cyc;
        @(negedge clk); #1;
        falls = 0; hi_cnt = 0; oe_gap = 0; busy_cyc = 0; min_run = 0; max_run = 0;
        last_run = 0; wr_cap = 8'd0;
        cmd_op = op; cmd_byte = b; speed_od = od; spu_en = spu; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        cyc = 0;
        while (!done && !timeout) begin
            if (busy) busy_cyc++;
            cyc++;
            if (inj_at != 0 && cyc == inj_at) begin
                cmd_op = 3'd0; cmd_valid = 1'b1;
            end else
                cmd_valid = 1'b0;
            @(negedge clk);
        end
        #1;
    endtask

    function automatic int wbyte_time(input logic [7:0] b, input logic od);
        int t = 0;
        for (int i = 0; i < 8; i++)
            t += b[i] ? (od ? 11 : 65) : (od ? 13 : 70);
        return t;
    endfunction

    initial begin
        wait (timeout);
        errors++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        chk(!busy && !done && !line_oe && !presence && !rd_bit && rd_byte == 8'd0,
            "R1 reset outputs", {busy, done, line_oe, presence}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 write-1 slots
        run_cmd(3'd1, 8'h01, 1'b0, 1'b0, 0);
        chk(falls == 1 && last_run == 1, "R2 write-1 std low", last_run, 1);
        chk(busy_cyc == 65, "R2 write-1 std slot", busy_cyc, 65);
        run_cmd(3'd1, 8'h01, 1'b1, 1'b0, 0);
        chk(busy_cyc == 11, "R2 write-1 od slot", busy_cyc, 11);

        // R3 write-0 slots
        run_cmd(3'd1, 8'h00, 1'b0, 1'b0, 0);
        chk(last_run == 60, "R3 write-0 std low", last_run, 60);
        chk(busy_cyc == 70, "R3 write-0 std slot", busy_cyc, 70);
        run_cmd(3'd1, 8'h00, 1'b1, 1'b0, 0);
        chk(last_run == 8, "R3 write-0 od low", last_run, 8);
        chk(busy_cyc == 13, "R3 write-0 od slot", busy_cyc, 13);

        // R4 read slots
        s_rd_mode = 1'b1;
        s_rd_pat = 8'h00;
        run_cmd(3'd2, 8'h00, 1'b0, 1'b0, 0);
        chk(rd_bit == 1'b0, "R4 read 0", rd_bit, 0);
        chk(busy_cyc == 57 && last_run == 1, "R4 read std slot", busy_cyc, 57);
        s_rd_pat = 8'hFF;
        run_cmd(3'd2, 8'h00, 1'b1, 1'b0, 0);
        chk(rd_bit == 1'b1, "R4 read 1", rd_bit, 1);
        chk(busy_cyc == 10, "R4 read od slot", busy_cyc, 10);
        s_rd_mode = 1'b0;

        // R5 / R6 / R7 resets
        s_answer_at = 1; s_lo = 65; s_hi = 70;
        run_cmd(3'd0, 8'h00, 1'b0, 1'b0, 0);
        chk(presence == 1'b1, "R6 presence seen", presence, 1);
        chk(falls == 1 && last_run == 500, "R5 reset low std", last_run, 500);
        chk(busy_cyc == 1590, "R5 reset std total", busy_cyc, 1590);
        s_answer_at = 0;
        run_cmd(3'd0, 8'h00, 1'b0, 1'b0, 0);
        chk(presence == 1'b0, "R7 no device", presence, 0);
        chk(falls == 3, "R7 three attempts", falls, 3);
        chk(busy_cyc == 3 * 1590, "R7 three attempt time", busy_cyc, 3 * 1590);
        s_answer_at = 2; s_lo = 70; s_hi = 75;
        run_cmd(3'd0, 8'h00, 1'b0, 1'b0, 0);
        chk(presence == 1'b1 && falls == 2, "R7 stop on second attempt", falls, 2);
        begin
            int pos [4] = '{60, 89, 59, 90};
            bit exp [4] = '{1'b1, 1'b1, 1'b0, 1'b0};
            for (int k = 0; k < 4; k++) begin
                s_answer_at = 1; s_lo = pos[k]; s_hi = pos[k];
                run_cmd(3'd0, 8'h00, 1'b0, 1'b0, 0);
                chk(presence == exp[k], "R6 window edge std", pos[k], int'(exp[k]));
                chk(falls == (exp[k] ? 1 : 3), "R7 attempts at edge", falls, exp[k] ? 1 : 3);
            end
        end
        s_answer_at = 1; s_lo = 30; s_hi = 30;
        run_cmd(3'd0, 8'h00, 1'b1, 1'b0, 0);
        chk(presence == 1'b1, "R6 window edge od", presence, 1);
        chk(last_run == 50 && busy_cyc == 121, "R5 reset od total", busy_cyc, 121);
        s_lo = 31; s_hi = 31;
        run_cmd(3'd0, 8'h00, 1'b1, 1'b0, 0);
        chk(presence == 1'b0, "R6 after window od", presence, 0);
        s_answer_at = 0;

        // R8 byte write sweep
        for (int v = 0; v < 256; v++) begin
            run_cmd(3'd3, 8'(v), 1'b1, 1'b0, 0);
            chk(falls == 8 && wr_cap == 8'(v), "R8 write byte order", int'(wr_cap), v);
            chk(busy_cyc == wbyte_time(8'(v), 1'b1), "R8 write byte time",
                busy_cyc, wbyte_time(8'(v), 1'b1));
        end

        // R8 byte read sweep
        s_rd_mode = 1'b1;
        for (int v = 0; v < 256; v++) begin
            s_rd_pat = 8'(v);
            run_cmd(3'd4, 8'h00, 1'b1, 1'b0, 0);
            chk(rd_byte == 8'(v) && busy_cyc == 80, "R8 read byte", int'(rd_byte), v);
        end
        s_rd_mode = 1'b0;

        // R10 strong pull-up
        run_cmd(3'd3, 8'hA5, 1'b0, 1'b1, 0);
        chk(hi_cnt == 12, "R10 pull-up cycles", hi_cnt, 12);
        chk(wr_cap == 8'hA5, "R10 byte intact", int'(wr_cap), 'hA5);
        chk(busy_cyc == wbyte_time(8'hA5, 1'b0) + 12, "R10 total time",
            busy_cyc, wbyte_time(8'hA5, 1'b0) + 12);
        run_cmd(3'd3, 8'hA5, 1'b0, 1'b0, 0);
        chk(hi_cnt == 0, "R10 no request no drive", hi_cnt, 0);

        // R9 open-drain drive
        od_mode = 1'b1;
        run_cmd(3'd1, 8'h00, 1'b0, 1'b0, 0);
        chk(oe_gap == 0, "R9 enable held", oe_gap, 0);
        chk(last_run == 60 && line_out == 1'b1, "R9 value drive", last_run, 60);
        od_mode = 1'b0;
        #1;
        chk(line_oe == 1'b0, "R9 released by enable", line_oe, 0);

        // R11 ignored commands
        run_cmd(3'd1, 8'h00, 1'b0, 1'b0, 10);
        chk(falls == 1 && busy_cyc == 70, "R11 busy ignores command", busy_cyc, 70);
        @(negedge clk);
        cmd_op = 3'd5; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (4) @(negedge clk);
        chk(!busy && !line_oe, "R11 illegal code ignored", busy, 0);

        // R12 slowed tick
        sparse = 1'b1;
        run_cmd(3'd1, 8'h00, 1'b1, 1'b0, 0);
        chk(last_run >= 15 && last_run <= 16, "R12 ticks counted", last_run, 16);
        sparse = 1'b0;

        report();
    end
endmodule